// File: doc/BRIEF.md
# Root Hub Port Status and Control Register Bank

This block holds the status/control word for each downstream port of a USB root hub. Each port has one 16-bit word. Software updates a word with a write strobe, a port index and data. The attached-device model reports attach, detach, device speed and remote-wakeup events on per-port wires. Within each word, some bits are read-only status, some are read/write control, and two status-change flags are cleared by writing 1 to them.

Two kinds of one-cycle request leave the block. A bus-reset request goes to the device on a port when software raises that port's reset bit and a device is connected. A resume request goes to the controller when a suspended port sees a wakeup.

Reads are combinational, selected by a read index. Bit 7 of every implemented port always reads as 1. An index beyond the implemented ports reads a fixed pattern, 0xFF7F.

Top module: `root_port_regs`

## Requirements
- R1: After controller reset every implemented port reads 0x0080, and no bus-reset or resume request is active.
- R2: A software write to a port leaves bits 0, 1, 3, 4, 5, 7 and 8 (mask 0x01BB) unchanged, and loads every other bit from the written data. Bits 4 and 5 stay 0, and bit 7 always reads 1.
- R3: Writing 1 to bit 1 (connect change) or bit 3 (enable change) clears that bit. Writing 0 to either leaves it unchanged.
- R4: bus_reset for a port pulses high for exactly the one cycle after a write that sets bit 9 (port reset). This happens only if bit 9 was 0 and bit 0 (connected) was 1 before that write.
- R5: An attach event sets bit 0 and bit 1, and loads bit 8 (low-speed device) from the port's speed input.
- R6: A detach event does two things. If bit 0 is set, it clears bit 0 and sets bit 1. If bit 2 (enable) is set, it clears bit 2 and sets bit 3. Otherwise it changes nothing.
- R7: A wakeup event on a port with bit 12 (suspend) set and bit 6 (resume detect) clear sets bit 6. It also drives resume_req high for the next cycle. In any other state, a wakeup changes nothing.
- R8: A read index at or above the number of implemented ports returns 0xFF7F. A write to such an index changes no port.
- R9: When a write and events hit the same port in one cycle, the write is applied first, then detach (or attach if there is no detach), then wakeup. Detach takes precedence over attach.
- R10: A write changes only the port its index selects. Events change only their own port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low controller reset |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | SEL_W | Port index for the write |
| wr_data | input | 16 | Write data |
| rd_sel | input | SEL_W | Port index for the read |
| rd_data | output | 16 | Read value of the selected port |
| dev_attach | input | NUM_PORTS | One-cycle device attach event per port |
| dev_detach | input | NUM_PORTS | One-cycle device detach event per port |
| dev_low_speed | input | NUM_PORTS | Speed of the attaching device, 1 = low speed |
| dev_wakeup | input | NUM_PORTS | One-cycle remote-wakeup event per port |
| bus_reset | output | NUM_PORTS | One-cycle bus-reset request to each port's device |
| resume_req | output | 1 | One-cycle resume indication to the controller |

## Verification
The assertions take for granted that every input is a known 0 or 1 at each clock edge. They also assume that the attach check only applies in cycles where no detach hits the same port, since detach wins under R9.

The stimulus holds events to single-cycle pulses and changes inputs only between edges. It draws write indices across both implemented and absent ports, so the absent-port read and the dropped write are both exercised. Simultaneous attach, detach, wakeup and write combinations are allowed on purpose, so that the ordering of R9 is reached under random traffic.

// File: rtl/uhp_pkg.sv
package uhp_pkg;

   localparam int REG_W = 16;

   localparam int B_CONN     = 0;
   localparam int B_CONN_CHG = 1;
   localparam int B_EN       = 2;
   localparam int B_EN_CHG   = 3;
   localparam int B_RES_DET  = 6;
   localparam int B_ONE      = 7;
   localparam int B_LOWSPD   = 8;
   localparam int B_BUSRST   = 9;
   localparam int B_SUSP     = 12;

   typedef logic [REG_W-1:0] portword_t;

   localparam portword_t HOLD_MASK   = 16'h01BB;
   localparam portword_t CLR1_MASK   = portword_t'((1 << B_CONN_CHG) | (1 << B_EN_CHG));
   localparam portword_t FORCE1_MASK = portword_t'(1 << B_ONE);
   localparam portword_t ABSENT_WORD = 16'hFF7F;

   typedef struct packed {
      logic attach;
      logic detach;
      logic low_speed;
      logic wakeup;
   } port_evt_t;

endpackage

// File: rtl/uhp_write_merge.sv
module uhp_write_merge
   import uhp_pkg::*;
(
   input  logic      hit,
   input  portword_t cur,
   input  portword_t data,
   output portword_t merged,
   output logic      rst_rise
);

   portword_t loaded;

   always_comb begin
      loaded = (cur & HOLD_MASK) | (data & ~HOLD_MASK);
      loaded = loaded & ~(data & CLR1_MASK);
      merged = hit ? loaded : cur;
      rst_rise = hit & data[B_BUSRST] & ~cur[B_BUSRST] & cur[B_CONN];
   end

endmodule

// File: rtl/uhp_port_cell.sv
module uhp_port_cell
   import uhp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_hit,
   input  portword_t wr_data,
   input  port_evt_t evt,
   output portword_t word_q,
   output logic      bus_rst_q,
   output logic      resume_q
);

   portword_t after_wr;
   portword_t after_evt;
   portword_t nxt;
   logic      rise;
   logic      wake_take;

   uhp_write_merge u_merge (
      .hit      (wr_hit),
      .cur      (word_q),
      .data     (wr_data),
      .merged   (after_wr),
      .rst_rise (rise)
   );

   // device events act on the word after the software write
   always_comb begin
      after_evt = after_wr;
      if (evt.detach) begin
         if (after_wr[B_CONN]) begin
            after_evt[B_CONN]     = 1'b0;
            after_evt[B_CONN_CHG] = 1'b1;
         end
         if (after_wr[B_EN]) begin
            after_evt[B_EN]     = 1'b0;
            after_evt[B_EN_CHG] = 1'b1;
         end
      end else if (evt.attach) begin
         after_evt[B_CONN]     = 1'b1;
         after_evt[B_CONN_CHG] = 1'b1;
         after_evt[B_LOWSPD]   = evt.low_speed;
      end
   end

   always_comb begin
      nxt       = after_evt;
      wake_take = evt.wakeup & after_evt[B_SUSP] & ~after_evt[B_RES_DET];
      if (wake_take) begin
         nxt[B_RES_DET] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q    <= '0;
         bus_rst_q <= 1'b0;
         resume_q  <= 1'b0;
      end else begin
         word_q    <= nxt;
         bus_rst_q <= rise;
         resume_q  <= wake_take;
      end
   end

endmodule

// File: rtl/uhp_read_mux.sv
module uhp_read_mux
   import uhp_pkg::*;
#(
   parameter int NUM_PORTS = 2,
   parameter int SEL_W     = 2
)(
   input  logic [NUM_PORTS-1:0][REG_W-1:0] words,
   input  logic [SEL_W-1:0]                sel,
   output portword_t                       rd
);

   localparam int SLOTS = 1 << SEL_W;

   generate
      if (NUM_PORTS == SLOTS) begin : g_full
         always_comb rd = words[sel] | FORCE1_MASK;
      end else begin : g_sparse
         logic in_range;
         always_comb begin
            in_range = ({1'b0, sel} < (SEL_W+1)'(NUM_PORTS));
            rd = ABSENT_WORD;
            for (int p = 0; p < NUM_PORTS; p++) begin
               if (in_range && sel == SEL_W'(p)) rd = words[p] | FORCE1_MASK;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/root_port_regs.sv
module root_port_regs
   import uhp_pkg::*;
#(
   parameter int NUM_PORTS = 2,
   parameter int SEL_W     = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic [15:0]          wr_data,
   input  logic [SEL_W-1:0]     rd_sel,
   output logic [15:0]          rd_data,
   input  logic [NUM_PORTS-1:0] dev_attach,
   input  logic [NUM_PORTS-1:0] dev_detach,
   input  logic [NUM_PORTS-1:0] dev_low_speed,
   input  logic [NUM_PORTS-1:0] dev_wakeup,
   output logic [NUM_PORTS-1:0] bus_reset,
   output logic                 resume_req
);

   generate
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("root_port_regs: NUM_PORTS must be at least 1");
      end
      if (SEL_W < 1 || NUM_PORTS > (1 << SEL_W)) begin : g_bad_sel
         $error("root_port_regs: SEL_W too narrow for NUM_PORTS");
      end
   endgenerate

   logic [NUM_PORTS-1:0][REG_W-1:0] port_state;
   logic [NUM_PORTS-1:0]            resume_each;

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      port_evt_t ev;
      logic      hit;
      portword_t word;
      always_comb begin
         ev.attach    = dev_attach[i];
         ev.detach    = dev_detach[i];
         ev.low_speed = dev_low_speed[i];
         ev.wakeup    = dev_wakeup[i];
         hit          = wr_en && (wr_sel == SEL_W'(i));
      end
      uhp_port_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_hit    (hit),
         .wr_data   (wr_data),
         .evt       (ev),
         .word_q    (word),
         .bus_rst_q (bus_reset[i]),
         .resume_q  (resume_each[i])
      );
      assign port_state[i] = word;
   end

   assign resume_req = |resume_each;

   uhp_read_mux #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_rd (
      .words (port_state),
      .sel   (rd_sel),
      .rd    (rd_data)
   );

endmodule

// File: rtl/root_port_regs_chk.sv
module root_port_regs_chk #(
   parameter int NUM_PORTS = 2,
   parameter int SEL_W     = 2
)(
   input logic                            clk,
   input logic                            rst_n,
   input logic                            wr_en,
   input logic [SEL_W-1:0]                wr_sel,
   input logic [15:0]                     wr_data,
   input logic [SEL_W-1:0]                rd_sel,
   input logic [15:0]                     rd_data,
   input logic [NUM_PORTS-1:0]            dev_attach,
   input logic [NUM_PORTS-1:0]            dev_detach,
   input logic [NUM_PORTS-1:0]            dev_low_speed,
   input logic [NUM_PORTS-1:0]            dev_wakeup,
   input logic [NUM_PORTS-1:0]            bus_reset,
   input logic                            resume_req,
   input logic [NUM_PORTS-1:0][15:0]      port_state
);

   a_r8_absent_read: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, rd_sel} >= (SEL_W+1)'(NUM_PORTS)) |-> (rd_data == 16'hFF7F));

   a_r7_resume_cause: assert property (@(posedge clk) disable iff (!rst_n)
      resume_req |-> $past(|dev_wakeup));

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
      a_r5_attach_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (dev_attach[i] && !dev_detach[i]) |=>
            (port_state[i][0] && port_state[i][1] && port_state[i][8] == $past(dev_low_speed[i])));

      a_r6_detach_clears: assert property (@(posedge clk) disable iff (!rst_n)
         dev_detach[i] |=> (!port_state[i][0] && !port_state[i][2]));

      a_r4_reset_edge: assert property (@(posedge clk) disable iff (!rst_n)
         bus_reset[i] |-> $past(wr_en && wr_sel == SEL_W'(i) && wr_data[9]
                                && !port_state[i][9] && port_state[i][0]));

      a_r2_hold_conn: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !dev_attach[i] && !dev_detach[i]) |=>
            ($stable(port_state[i][0]) && $stable(port_state[i][8])));
   end

endmodule

bind root_port_regs root_port_regs_chk #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_sel        (wr_sel),
   .wr_data       (wr_data),
   .rd_sel        (rd_sel),
   .rd_data       (rd_data),
   .dev_attach    (dev_attach),
   .dev_detach    (dev_detach),
   .dev_low_speed (dev_low_speed),
   .dev_wakeup    (dev_wakeup),
   .bus_reset     (bus_reset),
   .resume_req    (resume_req),
   .port_state    (port_state)
);

// File: tb/root_port_regs_test.sv
`timescale 1ns/100ps
module root_port_regs_test;

   localparam int NP = 2;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [SW-1:0] wr_sel = '0;
   logic [15:0]   wr_data = '0;
   logic [SW-1:0] rd_sel = '0;
   logic [15:0]   rd_data;
   logic [NP-1:0] dev_attach = '0;
   logic [NP-1:0] dev_detach = '0;
   logic [NP-1:0] dev_low_speed = '0;
   logic [NP-1:0] dev_wakeup = '0;
   logic [NP-1:0] bus_reset;
   logic          resume_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic [15:0] mdl [NP];

   always #2.5 clk = ~clk;

   root_port_regs #(.NUM_PORTS(NP), .SEL_W(SW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .dev_attach(dev_attach),
      .dev_detach(dev_detach), .dev_low_speed(dev_low_speed),
      .dev_wakeup(dev_wakeup), .bus_reset(bus_reset), .resume_req(resume_req)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_read(input int s);
      if (s >= NP) return 16'hFF7F;
      return mdl[s] | 16'h0080;
   endfunction

   // independent model of one port for one clock
   function automatic void step_port(input logic [15:0] cur, input bit wr, input logic [15:0] d,
                                     input bit at, input bit de, input bit ls, input bit wk,
                                     output logic [15:0] nx, output bit rp, output bit rs);
      nx = cur; rp = 0; rs = 0;
      if (wr) begin
         for (int b = 0; b < 16; b++)
            if (((16'h01BB >> b) & 16'h1) == 16'h0) nx[b] = d[b];
         if (d[1]) nx[1] = 1'b0;
         if (d[3]) nx[3] = 1'b0;
         rp = d[9] && !cur[9] && cur[0];
      end
      if (de) begin
         if (nx[0]) begin nx[0] = 1'b0; nx[1] = 1'b1; end
         if (nx[2]) begin nx[2] = 1'b0; nx[3] = 1'b1; end
      end else if (at) begin
         nx[0] = 1'b1; nx[1] = 1'b1; nx[8] = ls;
      end
      if (wk && nx[12] && !nx[6]) begin nx[6] = 1'b1; rs = 1; end
   endfunction

   // one clock with the current inputs; checks pulses then clears events
   task automatic cycle(input string req);
      logic [15:0] nx [NP];
      logic [NP-1:0] erp;
      bit ers = 0;
      for (int p = 0; p < NP; p++) begin
         bit a, b;
         step_port(mdl[p], wr_en && (wr_sel == SW'(p)), wr_data, dev_attach[p], dev_detach[p],
                   dev_low_speed[p], dev_wakeup[p], nx[p], a, b);
         erp[p] = a;
         ers = ers | b;
      end
      @(posedge clk);
      #1;
      for (int p = 0; p < NP; p++) mdl[p] = nx[p];
      check({req, " bus_reset"}, 16'(bus_reset), 16'(erp));
      check({req, " resume_req"}, 16'(resume_req), 16'(ers));
      wr_en = 0; dev_attach = '0; dev_detach = '0; dev_wakeup = '0;
   endtask

   task automatic rd_chk(input string req, input int s);
      rd_sel = SW'(s);
      #0.5;
      check(req, rd_data, exp_read(s));
   endtask

   task automatic wr(input int s, input logic [15:0] d);
      wr_en = 1; wr_sel = SW'(s); wr_data = d;
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      for (int p = 0; p < NP; p++) mdl[p] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state
      for (int s = 0; s < NP; s++) rd_chk("R1 reset read", s);
      check("R1 no pulses", 16'({bus_reset, resume_req}), 16'h0);
      check("R1 port0 literal", exp_read(0), 16'h0080);
      // R8: absent ports
      rd_chk("R8 absent read", 2);
      rd_chk("R8 absent read", 3);
      // R5: low-speed attach on port 0
      dev_attach[0] = 1; dev_low_speed[0] = 1;
      cycle("R5 attach");
      rd_sel = 0; #0.5 check("R5 attach word", rd_data, 16'h0183);
      // R10: port 1 untouched
      rd_chk("R10 port1 idle", 1);
      // R3: clear connect change, write 0 to enable change is harmless
      wr(0, 16'h0002);
      cycle("R3 w1c");
      rd_sel = 0; #0.5 check("R3 clear conn chg", rd_data, 16'h0181);
      // R2: try to drop read-only bits while setting enable + reset (R4 pulse)
      wr(0, 16'h0204);
      cycle("R4 reset rise");
      rd_sel = 0; #0.5 check("R2 RO kept", rd_data, 16'h0385);
      // R4: reset bit already 1, no second pulse
      wr(0, 16'h0204);
      cycle("R4 no repeat");
      // R4: no device on port 1, no pulse
      wr(1, 16'h0200);
      cycle("R4 no device");
      // R6: detach port 0
      dev_detach[0] = 1;
      cycle("R6 detach");
      rd_sel = 0; #0.5 check("R6 detach word", rd_data, 16'h038A);
      // R7: suspend port 1 then wake
      wr(1, 16'h1000);
      cycle("R7 suspend");
      dev_wakeup[1] = 1;
      cycle("R7 wake");
      rd_sel = 1; #0.5 check("R7 resume detect", rd_data, 16'h10C0);
      dev_wakeup[1] = 1;
      cycle("R7 second wake ignored");
      // R8: write to absent index ignored
      wr(3, 16'hFFFF);
      cycle("R8 absent write");
      rd_chk("R8 port0 unchanged", 0);
      rd_chk("R8 port1 unchanged", 1);
      // R9: write and attach plus detach together
      wr(1, 16'h0006); dev_attach[1] = 1; dev_detach[1] = 1;
      cycle("R9 same cycle");
      rd_chk("R9 order", 1);
      // constrained random traffic
      for (int k = 0; k < 3000; k++) begin
         wr_en = ($urandom_range(0, 9) < 3);
         wr_sel = SW'($urandom_range(0, 3));
         wr_data = 16'($urandom) & (($urandom_range(0, 1) != 0) ? 16'h1246 : 16'hFFFF);
         for (int p = 0; p < NP; p++) begin
            dev_attach[p] = ($urandom_range(0, 19) == 0);
            dev_detach[p] = ($urandom_range(0, 24) == 0);
            dev_low_speed[p] = 1'($urandom);
            dev_wakeup[p] = ($urandom_range(0, 9) == 0);
         end
         cycle("R9 random");
         rd_chk("R2 random read", int'($urandom_range(0, 3)));
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule